// File: doc/BRIEF.md
# Range-Based Output Selector with Per-Output Arbitration

This block makes the forwarding decision for a switch with many bidirectional links. Each input lane presents the header word that opens a packet. The block compares that word against a table of programmable boundaries, one lower boundary per output plus one upper limit. It picks the output whose half-open range holds the header. The decision is registered, so it appears one clock after the header.

A lane with a decision then waits for its output. The output must not already belong to another lane, and the link side must not report it busy. When several lanes wait for the same free output, a round-robin pointer kept for that output picks the winner. The winning lane keeps the output until it signals the end of its packet. A header that lies in no range is dropped, and an error pulse is raised on that lane.

The boundaries are written through a simple write port. In normal use they ascend, so each header selects exactly one output. Payload storage and link coding sit outside this block.

Top module: `range_route_switch`

## Requirements
- R1: After reset, no lane is waiting or connected, no error is raised and no output is allocated. Every boundary is zero, so any header is reported as a miss.
- R2: A write with `cfg_sel` equal to k (0 to N_LINKS-1) sets the lower boundary of output k. A write with `cfg_sel` equal to N_LINKS sets the exclusive upper limit of output N_LINKS-1.
- R3: A header h accepted on an idle lane makes that lane report waiting on the next clock, with `route_port` equal to the output k for which boundary[k] <= h < boundary[k+1]. If several ranges hold h, the lowest k is chosen.
- R4: A header that lies in no range raises `route_err` for that lane on the next clock. The lane stays idle and the packet is dropped.
- R5: A waiting lane is granted only while its output is unallocated and `out_busy` for that output is low. The grant shows as `lane_live` and `out_alloc` one clock after the arbitration cycle.
- R6: Lanes competing for one free output are served round-robin. The search starts at the lane after the previous winner of that output (lane 0 after reset), so the lowest index does not always win.
- R7: A connected lane keeps its output and port until `pkt_end` is seen on it. Lane and output are then free on the next clock. Another lane can be granted that output no earlier than the clock after that.
- R8: `hdr_valid` is ignored on a lane that is waiting or connected. Its port does not change and no error is raised.
- R9: `pkt_end` is ignored on a lane that is idle or waiting.
- R10: At most one lane is connected to any output at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Boundary write strobe |
| cfg_sel | input | $clog2(N_LINKS+1) | Boundary index (N_LINKS selects the upper limit) |
| cfg_bound | input | HDR_W | Boundary value |
| hdr_valid | input | N_LINKS | Per-lane header strobe |
| hdr_data | input | N_LINKS*HDR_W | Per-lane header words, lane i at bits i*HDR_W |
| pkt_end | input | N_LINKS | Per-lane end-of-packet strobe |
| out_busy | input | N_LINKS | Per-output link busy status |
| lane_wait | output | N_LINKS | Lane holds a decision and waits for a grant |
| lane_live | output | N_LINKS | Lane owns its output |
| route_port | output | N_LINKS*$clog2(N_LINKS) | Per-lane chosen output, lane i at bits i*$clog2(N_LINKS) |
| route_err | output | N_LINKS | Per-lane one-clock miss pulse |
| out_alloc | output | N_LINKS | Output is owned by a lane |

## Verification
The assertions assume that `pkt_end` is raised only by a lane that holds an output. They assume that `out_busy` stays high for as long as the link side is still sending. They also assume that boundary writes do not happen while a lane is waiting. Otherwise a decision already taken could disagree with the new table. The stimulus programs all boundaries before any header is sent, and reprograms them only when every lane is idle. It raises `pkt_end` on idle or waiting lanes only in the scenario that checks the strobe is ignored.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
   typedef enum logic [1:0] {
      LN_IDLE = 2'd0,
      LN_WAIT = 2'd1,
      LN_LIVE = 2'd2
   } lane_st_e;
endpackage

// File: rtl/rrs_bound_table.sv
module rrs_bound_table #(
   parameter int N_LINKS = 32,
   parameter int HDR_W   = 16,
   localparam int SEL_W  = $clog2(N_LINKS + 1)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cfg_we,
   input  logic [SEL_W-1:0]               cfg_sel,
   input  logic [HDR_W-1:0]               cfg_bound,
   output logic [(N_LINKS+1)*HDR_W-1:0]   bnd_flat
);
   generate
      for (genvar k = 0; k <= N_LINKS; k++) begin : g_ent
         logic [HDR_W-1:0] ent_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               ent_q <= '0;
            else if (cfg_we && (int'(cfg_sel) == k))
               ent_q <= cfg_bound;
         end
         assign bnd_flat[k*HDR_W +: HDR_W] = ent_q;
      end
   endgenerate
endmodule

// File: rtl/rrs_range_match.sv
module rrs_range_match #(
   parameter int N_LINKS = 32,
   parameter int HDR_W   = 16,
   localparam int PW     = $clog2(N_LINKS)
) (
   input  logic [HDR_W-1:0]               hdr,
   input  logic [(N_LINKS+1)*HDR_W-1:0]   bnd_flat,
   output logic                           hit,
   output logic [PW-1:0]                  hit_port
);
   logic [N_LINKS-1:0] in_rng;

   generate
      for (genvar o = 0; o < N_LINKS; o++) begin : g_cmp
         assign in_rng[o] = (hdr >= bnd_flat[o*HDR_W +: HDR_W]) &&
                            (hdr <  bnd_flat[(o+1)*HDR_W +: HDR_W]);
      end
   endgenerate

   // lowest matching output wins when ranges overlap
   always_comb begin
      hit      = 1'b0;
      hit_port = '0;
      for (int o = N_LINKS - 1; o >= 0; o--) begin
         if (in_rng[o]) begin
            hit      = 1'b1;
            hit_port = PW'(o);
         end
      end
   end
endmodule

// File: rtl/rrs_rr_pick.sv
module rrs_rr_pick #(
   parameter int N_REQ = 32,
   localparam int IW   = $clog2(N_REQ)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_REQ-1:0]  req,
   input  logic              en,
   output logic              gnt_v,
   output logic [IW-1:0]     gnt_idx
);
   logic [IW-1:0] ptr_q;
   logic          found;

   always_comb begin
      int unsigned j;
      found   = 1'b0;
      gnt_idx = '0;
      for (int k = 0; k < N_REQ; k++) begin
         j = int'(ptr_q) + k;
         if (j >= N_REQ) j = j - N_REQ;
         if (!found && req[j]) begin
            found   = 1'b1;
            gnt_idx = IW'(j);
         end
      end
   end

   assign gnt_v = en && found;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (gnt_v)
         ptr_q <= (int'(gnt_idx) == N_REQ - 1) ? '0 : gnt_idx + 1'b1;
   end

   a_r6_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_v |-> req[gnt_idx]);
endmodule

// File: rtl/rrs_lane.sv
module rrs_lane
   import rrs_pkg::*;
#(
   parameter int N_LINKS = 32,
   localparam int PW     = $clog2(N_LINKS)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hdr_valid,
   input  logic           hit,
   input  logic [PW-1:0]  hit_port,
   input  logic           gnt,
   input  logic           pkt_end,
   output lane_st_e       st,
   output logic [PW-1:0]  port,
   output logic           err
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= LN_IDLE;
         port <= '0;
         err  <= 1'b0;
      end else begin
         err <= 1'b0;
         unique case (st)
            LN_IDLE: if (hdr_valid) begin
               if (hit) begin
                  st   <= LN_WAIT;
                  port <= hit_port;
               end else begin
                  err <= 1'b1;
               end
            end
            LN_WAIT: if (gnt) st <= LN_LIVE;
            LN_LIVE: if (pkt_end) st <= LN_IDLE;
            default: st <= LN_IDLE;
         endcase
      end
   end

   a_r4_drop_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (st == LN_IDLE));
   a_r8_wait_port_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LN_WAIT) |=> (st != LN_IDLE) && $stable(port));
   a_r7_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LN_LIVE && !pkt_end) |=> (st == LN_LIVE) && $stable(port));
   a_r7_live_release: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LN_LIVE && pkt_end) |=> (st == LN_IDLE));
endmodule

// File: rtl/range_route_switch.sv
module range_route_switch
   import rrs_pkg::*;
#(
   parameter int N_LINKS = 32,
   parameter int HDR_W   = 16,
   localparam int PW     = $clog2(N_LINKS),
   localparam int SEL_W  = $clog2(N_LINKS + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [SEL_W-1:0]          cfg_sel,
   input  logic [HDR_W-1:0]          cfg_bound,
   input  logic [N_LINKS-1:0]        hdr_valid,
   input  logic [N_LINKS*HDR_W-1:0]  hdr_data,
   input  logic [N_LINKS-1:0]        pkt_end,
   input  logic [N_LINKS-1:0]        out_busy,
   output logic [N_LINKS-1:0]        lane_wait,
   output logic [N_LINKS-1:0]        lane_live,
   output logic [N_LINKS*PW-1:0]     route_port,
   output logic [N_LINKS-1:0]        route_err,
   output logic [N_LINKS-1:0]        out_alloc
);
   generate
      if (N_LINKS < 2) begin : g_bad_n
         $error("range_route_switch: N_LINKS must be at least 2");
      end
      if (HDR_W < 1) begin : g_bad_w
         $error("range_route_switch: HDR_W must be positive");
      end
   endgenerate

   logic [(N_LINKS+1)*HDR_W-1:0] bnd_flat;
   lane_st_e                     st      [N_LINKS];
   logic [PW-1:0]                lport   [N_LINKS];
   logic [N_LINKS-1:0]           lane_gnt;
   logic [N_LINKS-1:0]           gv;
   logic [PW-1:0]                gidx    [N_LINKS];
   logic [N_LINKS-1:0]           owned_q;
   logic [PW-1:0]                owner_q [N_LINKS];

   rrs_bound_table #(.N_LINKS(N_LINKS), .HDR_W(HDR_W)) i_tbl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_bound(cfg_bound), .bnd_flat(bnd_flat)
   );

   generate
      for (genvar i = 0; i < N_LINKS; i++) begin : g_lane
         logic          hit;
         logic [PW-1:0] hit_port;

         rrs_range_match #(.N_LINKS(N_LINKS), .HDR_W(HDR_W)) i_match (
            .hdr(hdr_data[i*HDR_W +: HDR_W]), .bnd_flat(bnd_flat),
            .hit(hit), .hit_port(hit_port)
         );

         rrs_lane #(.N_LINKS(N_LINKS)) i_lane (
            .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid[i]), .hit(hit),
            .hit_port(hit_port), .gnt(lane_gnt[i]), .pkt_end(pkt_end[i]),
            .st(st[i]), .port(lport[i]), .err(route_err[i])
         );

         assign lane_wait[i]            = (st[i] == LN_WAIT);
         assign lane_live[i]            = (st[i] == LN_LIVE);
         assign route_port[i*PW +: PW]  = lport[i];
      end

      for (genvar o = 0; o < N_LINKS; o++) begin : g_out
         logic [N_LINKS-1:0] req;
         logic [N_LINKS-1:0] live_on;
         logic               rel;

         for (genvar i = 0; i < N_LINKS; i++) begin : g_req
            assign req[i]     = (st[i] == LN_WAIT) && (int'(lport[i]) == o);
            assign live_on[i] = (st[i] == LN_LIVE) && (int'(lport[i]) == o);
         end

         rrs_rr_pick #(.N_REQ(N_LINKS)) i_arb (
            .clk(clk), .rst_n(rst_n), .req(req),
            .en(!owned_q[o] && !out_busy[o]),
            .gnt_v(gv[o]), .gnt_idx(gidx[o])
         );

         assign rel = owned_q[o] && pkt_end[owner_q[o]] &&
                      (st[owner_q[o]] == LN_LIVE);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               owned_q[o] <= 1'b0;
               owner_q[o] <= '0;
            end else if (gv[o]) begin
               owned_q[o] <= 1'b1;
               owner_q[o] <= gidx[o];
            end else if (rel) begin
               owned_q[o] <= 1'b0;
            end
         end

         a_r5_grant_when_free: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(owned_q[o]) |-> !$past(out_busy[o]));
         a_r10_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(live_on) <= 1);
         a_r7_owned_matches_live: assert property (@(posedge clk) disable iff (!rst_n)
            owned_q[o] == (|live_on));
      end
   endgenerate

   always_comb begin
      lane_gnt = '0;
      for (int o = 0; o < N_LINKS; o++) begin
         if (gv[o]) lane_gnt[gidx[o]] = 1'b1;
      end
   end

   assign out_alloc = owned_q;
endmodule

// File: tb/test_range_route_switch.sv
`timescale 1ns/1ps
module test_range_route_switch;
   localparam int N  = 4;
   localparam int HW = 8;
   localparam int PW = 2;
   localparam int SW = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 1'b0;
   logic [SW-1:0]   cfg_sel = '0;
   logic [HW-1:0]   cfg_bound = '0;
   logic [N-1:0]    hdr_valid = '0;
   logic [N*HW-1:0] hdr_data = '0;
   logic [N-1:0]    pkt_end = '0;
   logic [N-1:0]    out_busy = '0;
   logic [N-1:0]    lane_wait, lane_live, route_err, out_alloc;
   logic [N*PW-1:0] route_port;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   range_route_switch #(.N_LINKS(N), .HDR_W(HW)) i_range_route_switch (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_bound(cfg_bound), .hdr_valid(hdr_valid), .hdr_data(hdr_data),
      .pkt_end(pkt_end), .out_busy(out_busy), .lane_wait(lane_wait),
      .lane_live(lane_live), .route_port(route_port), .route_err(route_err),
      .out_alloc(out_alloc)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int portof(input int i);
      return int'(route_port[i*PW +: PW]);
   endfunction

   task automatic prog(input int sel, input int val);
      cfg_we = 1'b1; cfg_sel = SW'(sel); cfg_bound = HW'(val);
      step();
      cfg_we = 1'b0;
   endtask

   task automatic send(input int lane, input int h);
      hdr_valid[lane] = 1'b1;
      hdr_data[lane*HW +: HW] = HW'(h);
      step();
      hdr_valid[lane] = 1'b0;
   endtask

   task automatic finish_pkt(input int lane);
      pkt_end[lane] = 1'b1;
      step();
      pkt_end[lane] = 1'b0;
   endtask

   task automatic route_one(input int lane, input int h, input int expp);
      send(lane, h);
      chk(lane_wait[lane] && portof(lane) == expp, "R3 decision port", portof(lane), expp);
      step();
      chk(lane_live[lane] && out_alloc[expp], "R5 grant on free output", int'(lane_live), 1 << lane);
      finish_pkt(lane);
      chk(!lane_live[lane] && !out_alloc[expp], "R7 release after end", int'(out_alloc), 0);
   endtask

   task automatic t_reset();
      step(); step();
      rst_n = 1'b1;
      chk(lane_wait == 0 && lane_live == 0 && route_err == 0 && out_alloc == 0,
          "R1 reset state", int'({lane_wait, lane_live, route_err, out_alloc}), 0);
      send(0, 0);
      chk(route_err[0] && !lane_wait[0], "R1 zero bounds miss", int'(route_err), 1);
   endtask

   task automatic t_route();
      prog(0, 10); prog(1, 50); prog(2, 100); prog(3, 200); prog(4, 250);
      route_one(0, 10, 0);
      route_one(1, 49, 0);
      route_one(2, 50, 1);
      route_one(3, 249, 3);   // R2 upper limit is exclusive, 249 inside
      route_one(0, 150, 2);
   endtask

   task automatic t_miss();
      send(1, 9);
      chk(route_err[1] && !lane_wait[1], "R4 below first bound", int'(route_err), 2);
      step();
      chk(route_err == 0, "R4 error is one pulse", int'(route_err), 0);
      send(2, 250);
      chk(route_err[2] && !lane_wait[2], "R2 R4 at upper limit", int'(route_err), 4);
      send(3, 255);
      chk(route_err == 4'b1000 && lane_wait == 0, "R4 above limit", int'(route_err), 8);
   endtask

   task automatic t_busy();
      out_busy[1] = 1'b1;
      send(1, 60);
      chk(lane_wait[1] && portof(1) == 1, "R3 waiting on busy", portof(1), 1);
      step(); step();
      chk(!lane_live[1] && lane_wait[1] && !out_alloc[1], "R5 held off by busy", int'(lane_live), 0);
      finish_pkt(1);
      chk(lane_wait[1], "R9 end ignored while waiting", int'(lane_wait), 2);
      send(1, 120);
      chk(lane_wait[1] && portof(1) == 1 && route_err == 0, "R8 header ignored while waiting", portof(1), 1);
      out_busy[1] = 1'b0;
      step();
      chk(lane_live[1] && out_alloc[1], "R5 grant once free", int'(lane_live), 2);
      finish_pkt(1);
   endtask

   task automatic t_rr();
      // port 3: lane 3 was its last winner, so the search starts at lane 0
      hdr_valid[0] = 1'b1; hdr_valid[1] = 1'b1; hdr_valid[2] = 1'b1;
      hdr_data[0*HW +: HW] = 8'd220; hdr_data[1*HW +: HW] = 8'd220; hdr_data[2*HW +: HW] = 8'd220;
      step();
      hdr_valid = '0;
      chk(lane_wait == 4'b0111, "R3 three lanes waiting", int'(lane_wait), 7);
      step();
      chk(lane_live == 4'b0001, "R6 first winner lane0", int'(lane_live), 1);
      chk(lane_wait == 4'b0110, "R10 others keep waiting", int'(lane_wait), 6);
      finish_pkt(0);
      chk(lane_live == 0 && !out_alloc[3], "R7 no regrant in release cycle", int'(lane_live), 0);
      step();
      chk(lane_live == 4'b0010, "R6 second winner lane1", int'(lane_live), 2);
      finish_pkt(1);
      step();
      chk(lane_live == 4'b0100, "R6 third winner lane2", int'(lane_live), 4);
      finish_pkt(2);
      hdr_valid[0] = 1'b1; hdr_valid[3] = 1'b1;
      hdr_data[0*HW +: HW] = 8'd230; hdr_data[3*HW +: HW] = 8'd230;
      step();
      hdr_valid = '0;
      step();
      chk(lane_live == 4'b1000, "R6 rotation picks lane3 over lane0", int'(lane_live), 8);
      finish_pkt(3);
      step();
      chk(lane_live == 4'b0001, "R6 lane0 after lane3", int'(lane_live), 1);
      finish_pkt(0);
   endtask

   task automatic t_ignore();
      finish_pkt(2);
      chk(lane_live == 0 && lane_wait == 0 && out_alloc == 0 && route_err == 0,
          "R9 end ignored while idle", int'(out_alloc), 0);
      route_one(0, 20, 0);
      send(0, 20);
      step();
      send(0, 255);
      chk(lane_live[0] && route_err == 0 && portof(0) == 0, "R8 miss ignored while live", int'(route_err), 0);
      send(0, 120);
      chk(lane_live[0] && portof(0) == 0, "R8 header ignored while live", portof(0), 0);
      finish_pkt(0);
   endtask

   task automatic t_overlap();
      prog(2, 40);
      send(1, 45);
      chk(lane_wait[1] && portof(1) == 0, "R3 lowest range wins", portof(1), 0);
      step();
      finish_pkt(1);
      send(2, 150);
      chk(lane_wait[2] && portof(2) == 2, "R2 rewritten bound", portof(2), 2);
      step();
      finish_pkt(2);
   endtask

   initial begin
      t_reset();
      t_route();
      t_miss();
      t_busy();
      t_rr();
      t_ignore();
      t_overlap();
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule